// File: doc/BRIEF.md
# Weighted Round-Robin Queue Arbiter

This block decides which of several command submission queues is served next. Every queue reports whether it holds work and which of four priority classes it belongs to. A mode input selects either plain round-robin, where class labels are disregarded and all non-empty queues take turns, or weighted arbitration. In weighted arbitration an urgent class always wins. Three weighted classes (high, medium, low) follow it and share service according to per-class credit counters that are loaded from weight inputs.

A choice is offered on a valid/ready grant port as a queue index plus a burst size. After the consumer accepts it, the block counts one command per `cmd_taken` cycle. It stays committed to that queue until the burst size is reached or the queue runs dry. A queue that becomes ready in the meantime never interrupts a running burst. The mode, weights and burst code are read only while the block is idle. Fetching, data movement and queue storage are left to the neighbouring logic.

Top module: `wrr_queue_arbiter`

## Requirements
- R1: After reset, and whenever no queue flag is set while idle, `gnt_valid` is low.
- R2: With `mode_wrr` low, class labels are disregarded. Non-empty queues are offered in ascending cyclic order, starting just after the last queue granted in this mode (queue 0 is searched first after reset). Queues whose flag is low are skipped.
- R3: While `gnt_valid` is high and `gnt_ready` is low, `gnt_qid`, `gnt_burst` and `gnt_unlim` hold their values, whatever happens to the queue flags or configuration inputs.
- R4: With `mode_wrr` high, a queue of class 0 (urgent) is offered ahead of any queue of class 1, 2 or 3 whenever one is non-empty. Urgent grants leave the credit counters untouched.
- R5: Classes 1 (high), 2 (medium) and 3 (low) each own a credit counter. Among weighted classes that have a non-empty queue and credit left, the lowest class code wins, and its counter drops by one on acceptance. When no such class has credit, all three counters reload from `wt_high`, `wt_med` and `wt_low`, and a weight of 0 counts as 1.
- R6: Within one class in weighted mode, queues rotate in ascending cyclic order, starting after the last queue granted from that class.
- R7: A burst code n from 0 to 6 gives `gnt_burst` = 2^n with `gnt_unlim` low. Code 7 gives `gnt_unlim` high and `gnt_burst` = 0.
- R8: After acceptance, no new offer appears until `gnt_burst` cycles with `cmd_taken` high have passed. This holds even if an urgent queue becomes non-empty during the burst.
- R9: A burst ends as soon as the granted queue's flag goes low, even before its count is reached. An unlimited burst ends only that way.
- R10: Burst code and weights are captured when the offer is formed; changes to them during an offer or burst take effect only for later offers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wrr | input | 1 | 0 = plain round-robin, 1 = urgent plus weighted classes |
| q_nonempty | input | NQ | Per-queue work-present flag |
| q_class | input | 2*NQ | Per-queue class, bits 2q+1:2q; 0 urgent, 1 high, 2 medium, 3 low |
| wt_high | input | WW | Weight for class 1 |
| wt_med | input | WW | Weight for class 2 |
| wt_low | input | WW | Weight for class 3 |
| burst_code | input | BCW | Burst size exponent; all ones = unlimited |
| gnt_ready | input | 1 | Consumer accepts the offered grant |
| cmd_taken | input | 1 | One command taken from the granted queue this cycle |
| gnt_valid | output | 1 | A grant is offered |
| gnt_qid | output | clog2(NQ) | Offered queue index |
| gnt_burst | output | 2^BCW-1 | Offered burst size in commands (0 when unlimited) |
| gnt_unlim | output | 1 | Offered burst runs until the queue empties |

## Verification
The interesting coincidence is a credit reload and a credit decrement landing in the same accepting cycle. This happens on any acceptance of an offer formed when every busy weighted class had run out of credit. It is provoked by running several full weight rounds with uneven weights, and with a zero weight, over long enough sequences that reloads recur. It is judged by the exact order of granted queue indices, which is only right if the reload value and the decrement are combined correctly. A second overlap, a queue draining at the moment an urgent queue appears, is exercised by raising urgent work mid-burst and checking that the next offer, not the current burst, goes to it.

// File: rtl/wrr_arb_pkg.sv
package wrr_arb_pkg;

   typedef enum logic [1:0] {
      CLS_URGENT = 2'd0,
      CLS_HIGH   = 2'd1,
      CLS_MEDIUM = 2'd2,
      CLS_LOW    = 2'd3
   } prio_cls_e;

   typedef enum logic [1:0] {
      ARB_IDLE  = 2'd0,
      ARB_OFFER = 2'd1,
      ARB_BURST = 2'd2
   } arb_state_e;

   // lanes 0..3 are the per-class rotations, lane 4 is the plain rotation
   localparam int unsigned NUM_LANES = 5;
   localparam int unsigned RR_LANE   = 4;
   localparam int unsigned LANE_W    = 3;
   localparam int unsigned NUM_WCLS  = 3;

endpackage

// File: rtl/wrr_rr_pick.sv
module wrr_rr_pick #(
   parameter int unsigned NQ    = 8,
   parameter int unsigned IDX_W = 3
) (
   input  logic [NQ-1:0]    req,
   input  logic [IDX_W-1:0] last,
   output logic             found,
   output logic [IDX_W-1:0] pick
);

   initial begin
      assert (NQ >= 2 && (1 << IDX_W) >= NQ)
         else $error("wrr_rr_pick: IDX_W too small for NQ");
   end

   // search from the farthest offset down so the nearest requester wins
   always_comb begin
      int j;
      found = 1'b0;
      pick  = last;
      for (int i = NQ; i >= 1; i--) begin
         j = int'(last) + i;
         if (j >= int'(NQ)) j = j - int'(NQ);
         if (req[IDX_W'(j)]) begin
            found = 1'b1;
            pick  = IDX_W'(j);
         end
      end
   end

endmodule

// File: rtl/wrr_credit_bank.sv
module wrr_credit_bank
   import wrr_arb_pkg::*;
#(
   parameter int unsigned WW = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_WCLS-1:0][WW-1:0]   weight,
   input  logic [NUM_WCLS-1:0]           cls_busy,
   input  logic                          take,
   input  logic [1:0]                    take_cls,
   input  logic                          take_reload,
   output logic [NUM_WCLS-1:0]           eligible,
   output logic                          reload_need
);

   initial begin
      assert (WW >= 1 && WW <= 16) else $error("wrr_credit_bank: WW out of range");
   end

   logic [WW-1:0]         credit [NUM_WCLS];
   logic [WW-1:0]         eff_w  [NUM_WCLS];
   logic [NUM_WCLS-1:0]   credit_nz;

   for (genvar k = 0; k < NUM_WCLS; k++) begin : g_cls
      assign eff_w[k]     = (weight[k] == '0) ? WW'(1) : weight[k];
      assign credit_nz[k] = (credit[k] != '0);
   end

   assign reload_need = ~|(cls_busy & credit_nz);
   assign eligible    = cls_busy & (reload_need ? {NUM_WCLS{1'b1}} : credit_nz);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NUM_WCLS; k++) credit[k] <= '0;
      end else if (take) begin
         for (int k = 0; k < NUM_WCLS; k++) begin
            if (take_cls == 2'(k))
               credit[k] <= (take_reload ? eff_w[k] : credit[k]) - WW'(1);
            else if (take_reload)
               credit[k] <= eff_w[k];
         end
      end
   end

   // R5: a weighted grant without reload must draw on remaining credit
   p_take_has_credit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !take_reload) |-> (take_cls < 2'd3 && credit[take_cls] != '0))
      else $error("p_take_has_credit_r5");

   p_take_cls_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> take_cls < 2'd3)
      else $error("p_take_cls_range_r5");

endmodule

// File: rtl/wrr_burst_ctrl.sv
module wrr_burst_ctrl #(
   parameter int unsigned BCW   = 3,
   parameter int unsigned CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BCW-1:0]   code,
   input  logic             start,
   input  logic             cmd_taken,
   input  logic             q_alive,
   output logic [CNT_W-1:0] burst_len,
   output logic             unlim,
   output logic             end_now
);

   initial begin
      assert (CNT_W == (1 << BCW) - 1) else $error("wrr_burst_ctrl: CNT_W mismatch");
   end

   logic             busy;
   logic             unl_l;
   logic [CNT_W-1:0] lim_l;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_nxt;
   logic             last_cmd;

   assign unlim     = &code;
   assign burst_len = unlim ? '0 : (CNT_W'(1) << code);

   assign cnt_nxt  = cnt + CNT_W'(1);
   assign last_cmd = cmd_taken && !unl_l && (cnt_nxt == lim_l);
   assign end_now  = busy && (!q_alive || last_cmd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         unl_l <= 1'b0;
         lim_l <= '0;
         cnt   <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         unl_l <= unlim;
         lim_l <= burst_len;
         cnt   <= '0;
      end else if (end_now) begin
         busy  <= 1'b0;
      end else if (busy && cmd_taken) begin
         cnt   <= cnt_nxt;
      end
   end

   // R8: a limited burst never counts past its size
   p_cnt_below_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !unl_l) |-> (cnt < lim_l))
      else $error("p_cnt_below_limit_r8");

   // R7: a limited burst size is a single power of two
   p_len_pow2_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !unlim) |-> ($countones(burst_len) == 1))
      else $error("p_len_pow2_r7");

endmodule

// File: rtl/wrr_queue_arbiter.sv
module wrr_queue_arbiter
   import wrr_arb_pkg::*;
#(
   parameter int unsigned NQ  = 8,
   parameter int unsigned WW  = 8,
   parameter int unsigned BCW = 3,
   localparam int unsigned IDX_W = (NQ > 1) ? $clog2(NQ) : 1,
   localparam int unsigned CNT_W = (1 << BCW) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wrr,
   input  logic [NQ-1:0]     q_nonempty,
   input  logic [2*NQ-1:0]   q_class,
   input  logic [WW-1:0]     wt_high,
   input  logic [WW-1:0]     wt_med,
   input  logic [WW-1:0]     wt_low,
   input  logic [BCW-1:0]    burst_code,
   input  logic              gnt_ready,
   input  logic              cmd_taken,
   output logic              gnt_valid,
   output logic [IDX_W-1:0]  gnt_qid,
   output logic [CNT_W-1:0]  gnt_burst,
   output logic              gnt_unlim
);

   initial begin
      assert (NQ >= 2 && NQ <= 256) else $error("wrr_queue_arbiter: NQ out of range");
      assert (BCW >= 2 && BCW <= 4) else $error("wrr_queue_arbiter: BCW out of range");
      assert (WW >= 1 && WW <= 16)  else $error("wrr_queue_arbiter: WW out of range");
   end

   arb_state_e                  st;
   logic [3:0][NQ-1:0]          creq;
   logic [NUM_WCLS-1:0]         cls_busy;
   logic [NUM_LANES-1:0]        lane_found;
   logic [IDX_W-1:0]            lane_pick [NUM_LANES];
   logic [IDX_W-1:0]            ptr       [NUM_LANES];

   logic [NUM_WCLS-1:0][WW-1:0] wt_live;
   logic [NUM_WCLS-1:0][WW-1:0] wt_shadow;
   logic [NUM_WCLS-1:0][WW-1:0] wt_cur;
   logic [NUM_WCLS-1:0]         eligible;
   logic                        reload_need;

   logic                        sel_found;
   logic [IDX_W-1:0]            sel_q;
   logic [LANE_W-1:0]           sel_lane;
   logic                        sel_w;
   logic [1:0]                  sel_wcls;

   logic [IDX_W-1:0]            off_q;
   logic [LANE_W-1:0]           off_lane;
   logic                        off_w;
   logic [1:0]                  off_wcls;
   logic                        off_reload;
   logic [BCW-1:0]              off_code;

   logic                        accept;
   logic                        take;
   logic                        burst_end;
   logic                        q_alive;

   // ---------------- per-class request vectors ----------------
   always_comb begin
      creq = '0;
      for (int q = 0; q < NQ; q++) begin
         for (int c = 0; c < 4; c++) begin
            if (q_nonempty[q] && (q_class[2*q +: 2] == 2'(c))) creq[c][q] = 1'b1;
         end
      end
   end

   for (genvar k = 0; k < NUM_WCLS; k++) begin : g_busy
      assign cls_busy[k] = |creq[k+1];
   end

   // ---------------- rotation pickers ----------------
   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      logic [NQ-1:0] lane_req;
      if (l == RR_LANE) begin : g_plain
         assign lane_req = q_nonempty;
      end else begin : g_class
         assign lane_req = creq[l];
      end
      wrr_rr_pick #(.NQ(NQ), .IDX_W(IDX_W)) u_pick (
         .req   (lane_req),
         .last  (ptr[l]),
         .found (lane_found[l]),
         .pick  (lane_pick[l])
      );
   end

   // ---------------- weights: live while idle, frozen otherwise ----------------
   assign wt_live = {wt_low, wt_med, wt_high};
   assign wt_cur  = (st == ARB_IDLE) ? wt_live : wt_shadow;

   assign accept = (st == ARB_OFFER) && gnt_ready;
   assign take   = accept && off_w;

   wrr_credit_bank #(.WW(WW)) u_credit (
      .clk         (clk),
      .rst_n       (rst_n),
      .weight      (wt_cur),
      .cls_busy    (cls_busy),
      .take        (take),
      .take_cls    (off_wcls),
      .take_reload (off_reload),
      .eligible    (eligible),
      .reload_need (reload_need)
   );

   // ---------------- selection ----------------
   always_comb begin
      sel_found = 1'b0;
      sel_q     = lane_pick[RR_LANE];
      sel_lane  = LANE_W'(RR_LANE);
      sel_w     = 1'b0;
      sel_wcls  = 2'd0;
      if (!mode_wrr) begin
         sel_found = lane_found[RR_LANE];
      end else if (lane_found[0]) begin
         sel_found = 1'b1;
         sel_q     = lane_pick[0];
         sel_lane  = LANE_W'(0);
      end else begin
         for (int k = NUM_WCLS - 1; k >= 0; k--) begin
            if (eligible[k]) begin
               sel_found = 1'b1;
               sel_q     = lane_pick[k+1];
               sel_lane  = LANE_W'(k + 1);
               sel_w     = 1'b1;
               sel_wcls  = 2'(k);
            end
         end
      end
   end

   // ---------------- burst tracking ----------------
   assign q_alive = q_nonempty[off_q];

   wrr_burst_ctrl #(.BCW(BCW), .CNT_W(CNT_W)) u_burst (
      .clk       (clk),
      .rst_n     (rst_n),
      .code      (off_code),
      .start     (accept),
      .cmd_taken (cmd_taken),
      .q_alive   (q_alive),
      .burst_len (gnt_burst),
      .unlim     (gnt_unlim),
      .end_now   (burst_end)
   );

   // ---------------- control ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ARB_IDLE;
         off_q      <= '0;
         off_lane   <= '0;
         off_w      <= 1'b0;
         off_wcls   <= 2'd0;
         off_reload <= 1'b0;
         off_code   <= '0;
         wt_shadow  <= '0;
      end else begin
         unique case (st)
            ARB_IDLE: begin
               wt_shadow <= wt_live;
               off_code  <= burst_code;
               if (sel_found) begin
                  st         <= ARB_OFFER;
                  off_q      <= sel_q;
                  off_lane   <= sel_lane;
                  off_w      <= sel_w;
                  off_wcls   <= sel_wcls;
                  off_reload <= reload_need;
               end
            end
            ARB_OFFER: if (gnt_ready) st <= ARB_BURST;
            ARB_BURST: if (burst_end) st <= ARB_IDLE;
            default:   st <= ARB_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int l = 0; l < NUM_LANES; l++) ptr[l] <= IDX_W'(NQ - 1);
      end else if (accept) begin
         for (int l = 0; l < NUM_LANES; l++) begin
            if (off_lane == LANE_W'(l)) ptr[l] <= off_q;
         end
      end
   end

   assign gnt_valid = (st == ARB_OFFER);
   assign gnt_qid   = off_q;

   // ---------------- assertions ----------------
   p_idle_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ARB_IDLE && q_nonempty == '0) |=> !gnt_valid)
      else $error("p_idle_empty_r1");

   p_offer_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gnt_valid) |-> (|($past(q_nonempty) & (NQ'(1) << gnt_qid))))
      else $error("p_offer_nonempty_r2");

   p_offer_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && !gnt_ready) |=>
         (gnt_valid && $stable(gnt_qid) && $stable(gnt_burst) && $stable(gnt_unlim)))
      else $error("p_offer_stable_r3");

   p_urgent_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(gnt_valid) && $past(mode_wrr) && $past(|creq[0])) |->
         (2'($past(q_class) >> (2 * gnt_qid)) == 2'(CLS_URGENT)))
      else $error("p_urgent_first_r4");

   p_no_offer_in_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ARB_BURST && !burst_end) |=> !gnt_valid)
      else $error("p_no_offer_in_burst_r8");

endmodule

// File: tb/wrr_queue_arbiter_bench.sv
module wrr_queue_arbiter_bench;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int NQ = 8;
   localparam int WW = 8;
   localparam int BCW = 3;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            mode_wrr;
   logic [NQ-1:0]   q_nonempty;
   logic [2*NQ-1:0] q_class;
   logic [WW-1:0]   wt_high, wt_med, wt_low;
   logic [BCW-1:0]  burst_code;
   logic            gnt_ready, cmd_taken;
   logic            gnt_valid;
   logic [2:0]      gnt_qid;
   logic [6:0]      gnt_burst;
   logic            gnt_unlim;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   wrr_queue_arbiter #(.NQ(NQ), .WW(WW), .BCW(BCW)) u_wrr_queue_arbiter (
      .clk(clk), .rst_n(rst_n), .mode_wrr(mode_wrr), .q_nonempty(q_nonempty),
      .q_class(q_class), .wt_high(wt_high), .wt_med(wt_med), .wt_low(wt_low),
      .burst_code(burst_code), .gnt_ready(gnt_ready), .cmd_taken(cmd_taken),
      .gnt_valid(gnt_valid), .gnt_qid(gnt_qid), .gnt_burst(gnt_burst),
      .gnt_unlim(gnt_unlim));

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic set_cls(input int q, input int c);
      q_class[2*q +: 2] = 2'(c);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; mode_wrr = 1'b0; q_nonempty = '0; q_class = '1;
      wt_high = 8'd1; wt_med = 8'd1; wt_low = 8'd1; burst_code = '0;
      gnt_ready = 1'b0; cmd_taken = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // waits at negedges for an offer; returns -1 on timeout
   task automatic wait_offer(output int q);
      q = -1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (gnt_valid) begin
            q = int'(gnt_qid);
            break;
         end
      end
   endtask

   task automatic accept();
      gnt_ready = 1'b1;
      @(negedge clk);
      gnt_ready = 1'b0;
   endtask

   task automatic take(input int n);
      cmd_taken = 1'b1;
      repeat (n) @(negedge clk);
      cmd_taken = 1'b0;
   endtask

   task automatic expect_grant(input string tag, input int exp_q);
      int q;
      wait_offer(q);
      chk(tag, q, exp_q);
      if (q >= 0) begin
         accept();
         take(gnt_unlim ? 1 : int'(gnt_burst));
      end
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 valid after reset", gnt_valid, 0);
      repeat (4) @(negedge clk);
      chk("R1 valid with no queue", gnt_valid, 0);
   endtask

   task automatic t_rr();
      do_reset();
      q_nonempty = 8'b0100_1010;
      set_cls(6, 0);
      expect_grant("R2 rr first", 1);
      expect_grant("R2 rr second", 3);
      expect_grant("R2 rr third", 6);
      expect_grant("R2 rr wrap", 1);
      expect_grant("R2 rr again", 3);
   endtask

   task automatic t_offer_hold();
      int q;
      bit held;
      do_reset();
      burst_code = 3'd1;
      q_nonempty = 8'b0000_0100;
      wait_offer(q);
      chk("R3 offer qid", q, 2);
      chk("R7 code 1 size", gnt_burst, 2);
      burst_code = 3'd5;
      q_nonempty[0] = 1'b1;
      mode_wrr = 1'b1;
      held = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (!gnt_valid || gnt_qid != 3'd2 || gnt_burst != 7'd2) held = 1'b0;
      end
      chk("R3 held while not ready", held, 1);
      mode_wrr = 1'b0;
      accept();
      take(2);
      wait_offer(q);
      chk("R10 next rr qid", q, 0);
      chk("R10 new code applies later", gnt_burst, 32);
      accept();
      take(32);
   endtask

   task automatic t_codes();
      int q;
      do_reset();
      q_nonempty = 8'b0000_0001;
      for (int c = 0; c < 7; c++) begin
         burst_code = 3'(c);
         wait_offer(q);
         chk($sformatf("R7 size code %0d", c), gnt_burst, 1 << c);
         chk($sformatf("R7 unlim low code %0d", c), gnt_unlim, 0);
         accept();
         take(1 << c);
      end
   endtask

   task automatic t_burst();
      int q;
      do_reset();
      mode_wrr = 1'b1;
      burst_code = 3'd2;
      q_nonempty = 8'b0000_1000;
      set_cls(3, 3);
      wait_offer(q);
      chk("R8 burst qid", q, 3);
      chk("R7 code 2 size", gnt_burst, 4);
      accept();
      take(3);
      set_cls(5, 0);
      q_nonempty[5] = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8 no preempt by urgent", gnt_valid, 0);
      take(1);
      wait_offer(q);
      chk("R4 urgent after burst", q, 5);
      accept();
      take(4);
   endtask

   task automatic t_unlim();
      int q;
      do_reset();
      burst_code = 3'd7;
      q_nonempty = 8'b0001_0010;
      wait_offer(q);
      chk("R9 unlim qid", q, 1);
      chk("R7 code 7 unlim", gnt_unlim, 1);
      chk("R7 code 7 size", gnt_burst, 0);
      accept();
      take(20);
      chk("R9 unlim still running", gnt_valid, 0);
      burst_code = 3'd3;
      q_nonempty[1] = 1'b0;
      wait_offer(q);
      chk("R9 ends on empty", q, 4);
      chk("R7 code 3 size", gnt_burst, 8);
      accept();
      take(2);
      q_nonempty[1] = 1'b1;
      q_nonempty[4] = 1'b0;
      wait_offer(q);
      chk("R9 early end", q, 1);
      accept();
      take(8);
   endtask

   task automatic t_urgent();
      do_reset();
      mode_wrr = 1'b1;
      q_nonempty = 8'b0010_0101;
      set_cls(0, 3); set_cls(2, 0); set_cls(5, 1);
      expect_grant("R4 urgent 1", 2);
      expect_grant("R4 urgent 2", 2);
      expect_grant("R4 urgent 3", 2);
      q_nonempty[2] = 1'b0;
      expect_grant("R5 high after urgent", 5);
   endtask

   task automatic t_weights();
      int exp_seq[8] = '{1, 1, 4, 7, 1, 1, 4, 7};
      do_reset();
      mode_wrr = 1'b1;
      wt_high = 8'd2; wt_med = 8'd1; wt_low = 8'd1;
      q_nonempty = 8'b1001_0010;
      set_cls(1, 1); set_cls(4, 2); set_cls(7, 3);
      foreach (exp_seq[i]) expect_grant($sformatf("R5 weighted step %0d", i), exp_seq[i]);
   endtask

   task automatic t_rotate();
      int exp_seq[8] = '{1, 3, 1, 4, 3, 1, 3, 4};
      do_reset();
      mode_wrr = 1'b1;
      wt_high = 8'd3; wt_med = 8'd1;
      q_nonempty = 8'b0001_1010;
      set_cls(1, 1); set_cls(3, 1); set_cls(4, 2);
      foreach (exp_seq[i]) expect_grant($sformatf("R6 class rotate step %0d", i), exp_seq[i]);
   endtask

   task automatic t_zero_weight();
      int exp_seq[4] = '{1, 4, 1, 4};
      do_reset();
      mode_wrr = 1'b1;
      wt_high = 8'd0; wt_med = 8'd1;
      q_nonempty = 8'b0001_0010;
      set_cls(1, 1); set_cls(4, 2);
      foreach (exp_seq[i]) expect_grant($sformatf("R5 zero weight step %0d", i), exp_seq[i]);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_run();
   end

   initial begin
      t_reset();
      t_rr();
      t_offer_hold();
      t_codes();
      t_burst();
      t_unlim();
      t_urgent();
      t_weights();
      t_rotate();
      t_zero_weight();
      finish_run();
   end

endmodule